// File: doc/BRIEF.md
# Register-Driven Single-Byte SPI Master

This block is an SPI master that software drives through four word addresses on a simple synchronous register bus. A configuration word sets the clock polarity, the sampling phase and a two-factor prescaler. A control word picks one of eight active-low chip selects, enables it, and holds a completion flag. Writing a byte to the transmit address starts one full-duplex exchange of eight bits. The byte received on the serial input is then readable at the receive address.

Software uses it in a fixed sequence. It writes the configuration once. It writes the control word with the chip-select number, the enable bit set and the flag cleared. It then writes each byte and polls the flag, which hardware sets when the exchange ends. Before the next byte it clears the flag, and when the transaction is over it clears the enable bit.

Top module: `spi_byte_master`

## Requirements
- R1: One SCK period lasts D core cycles, where D is the SPR field times 2 to the power of the SPPR field, and any D below 2 runs as 2. A byte takes exactly 8·D core cycles, counted from the clock edge that accepts the transmit write to the edge that sets the completion flag.
- R2: Address 0 is the read/write configuration word. SPR is in bits 3:0. The lowest SPPR bit is in bit 4 and SPPR bits 2:1 are in bits 6:5. CPOL is bit 7 and the phase bit is bit 8. Reading address 0 returns the value written.
- R3: Phase bit 1 makes both sides sample on the leading SCK edge, with MOSI valid before that edge. Phase bit 0 makes MOSI change on the leading edge and both sides sample on the trailing edge.
- R4: Between bytes SCK rests at the CPOL level. Each byte produces exactly 16 SCK transitions.
- R5: Bits are shifted most significant first, in both directions at once. Address 2 is write-only transmit data (it reads as 0). After completion, address 3 returns the byte received on MISO.
- R6: Address 1 is the control word: bit 0 is the completion flag, bit 1 enables chip select, and bits 4:2 give the chip-select number. cs_n_o[k] is low only when the enable bit is set and the number equals k. When the enable bit is clear, every chip select is high.
- R7: Hardware sets the completion flag when a byte ends. A control write with bit 0 at 0 clears the flag. A control write with bit 0 at 1 leaves the flag unchanged.
- R8: A transmit write that arrives while a byte is shifting is ignored. The byte in progress, its length and the received data are unaffected.
- R9: After reset all registers read 0, SCK and MOSI are low, and all chip selects are high.
- R10: An SPR field of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | BUS_W | Write data |
| reg_we_i | input | 1 | Write strobe, one cycle per write |
| reg_rdata_o | output | BUS_W | Read data for reg_addr_i, combinational |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 8 | Chip selects, active low |

## Verification
The exchange is run with transmit and slave bytes that are complementary, alternating, all ones and all zeros. A bit-order or lane swap cannot pass all of these at once.

The prescaler settings cover an even divider, an odd divider, a divider that is clamped to 2, an SPR of 0, and SPPR values whose bits fall on both sides of the split field. The cycle count per byte therefore separates a misplaced field bit from a wrong multiplication.

Each of the four polarity and phase pairs is run against a slave model that samples only on the edge its mode allows. A wrong edge choice shows up as a corrupted byte rather than as an off-by-one in timing.

// File: rtl/spi_bm_pkg.sv
`timescale 1ns/1ps
package spi_bm_pkg;
  localparam int SPR_W   = 4;
  localparam int SPPR_W  = 3;
  localparam int CS_W    = 3;
  localparam int N_CS    = 1 << CS_W;
  localparam int BYTE_W  = 8;
  localparam int DIV_W   = SPR_W + (1 << SPPR_W) - 1;

  // configuration field positions; SPPR is split around bit 4
  localparam int CFG_SPPR0 = SPR_W;
  localparam int CFG_SPPRH = SPR_W + 1;
  localparam int CFG_CPOL  = CFG_SPPRH + SPPR_W - 1;
  localparam int CFG_PH    = CFG_CPOL + 1;
  localparam int CFG_TOP   = CFG_PH;

  localparam int CTL_RDY   = 0;
  localparam int CTL_ACT   = 1;
  localparam int CTL_NUM   = 2;
  localparam int CTL_TOP   = CTL_NUM + CS_W - 1;

  typedef enum logic [1:0] {
    ADDR_CFG  = 2'd0,
    ADDR_CTRL = 2'd1,
    ADDR_TXD  = 2'd2,
    ADDR_RXD  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/spi_bm_regs.sv
`timescale 1ns/1ps
module spi_bm_regs
  import spi_bm_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic              we_i,
  output logic [BUS_W-1:0]  rdata_o,
  input  logic              busy_i,
  input  logic              done_i,
  input  logic [BYTE_W-1:0] rx_byte_i,
  output logic [SPR_W-1:0]  spr_o,
  output logic [SPPR_W-1:0] sppr_o,
  output logic              cpol_o,
  output logic              ph_first_o,
  output logic [CS_W-1:0]   cs_num_o,
  output logic              cs_act_o,
  output logic              start_o,
  output logic [BYTE_W-1:0] tx_byte_o
);
  logic [SPR_W-1:0]  spr_q;
  logic [SPPR_W-1:0] sppr_q;
  logic              cpol_q, ph_q, rdy_q, act_q;
  logic [CS_W-1:0]   num_q;
  logic [BYTE_W-1:0] rx_q;
  logic              wr_cfg, wr_ctl;
  logic [CFG_TOP:0]  cfg_word;
  logic [CTL_TOP:0]  ctl_word;
  logic              unused_wdata;

  assign unused_wdata = ^wdata_i[BUS_W-1:CFG_TOP+1];
  assign wr_cfg  = we_i && (addr_i == ADDR_CFG);
  assign wr_ctl  = we_i && (addr_i == ADDR_CTRL);
  assign start_o = we_i && (addr_i == ADDR_TXD) && !busy_i;
  assign tx_byte_o = wdata_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spr_q  <= '0;
      sppr_q <= '0;
      cpol_q <= 1'b0;
      ph_q   <= 1'b0;
      rdy_q  <= 1'b0;
      act_q  <= 1'b0;
      num_q  <= '0;
      rx_q   <= '0;
    end else begin
      if (wr_cfg) begin
        spr_q  <= wdata_i[SPR_W-1:0];
        sppr_q <= {wdata_i[CFG_CPOL-1:CFG_SPPRH], wdata_i[CFG_SPPR0]};
        cpol_q <= wdata_i[CFG_CPOL];
        ph_q   <= wdata_i[CFG_PH];
      end
      if (wr_ctl) begin
        act_q <= wdata_i[CTL_ACT];
        num_q <= wdata_i[CTL_TOP:CTL_NUM];
      end
      // hardware set wins; software may only clear
      if (done_i)                            rdy_q <= 1'b1;
      else if (wr_ctl && !wdata_i[CTL_RDY])  rdy_q <= 1'b0;
      if (done_i) rx_q <= rx_byte_i;
    end
  end

  assign cfg_word = {ph_q, cpol_q, sppr_q[SPPR_W-1:1], sppr_q[0], spr_q};
  assign ctl_word = {num_q, act_q, rdy_q};

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CFG:  rdata_o[CFG_TOP:0] = cfg_word;
      ADDR_CTRL: rdata_o[CTL_TOP:0] = ctl_word;
      ADDR_TXD:  rdata_o = '0;
      ADDR_RXD:  rdata_o[BYTE_W-1:0] = rx_q;
      default:   rdata_o = '0;
    endcase
  end

  assign spr_o      = spr_q;
  assign sppr_o     = sppr_q;
  assign cpol_o     = cpol_q;
  assign ph_first_o = ph_q;
  assign cs_num_o   = num_q;
  assign cs_act_o   = act_q;

  assert_ready_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_q) |-> $past(busy_i));
endmodule

// File: rtl/spi_bm_timer.sv
`timescale 1ns/1ps
module spi_bm_timer
  import spi_bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [SPR_W-1:0]  spr_i,
  input  logic [SPPR_W-1:0] sppr_i,
  input  logic              cpol_i,
  output logic              lead_o,
  output logic              trail_o,
  output logic              sck_o
);
  logic [DIV_W-1:0] spr_eff, div_raw, div, half, pc_q;
  logic             sck_q;

  always_comb begin
    spr_eff = (spr_i == '0) ? DIV_W'(1) : DIV_W'(spr_i);
    div_raw = spr_eff << sppr_i;
    div     = (div_raw < DIV_W'(2)) ? DIV_W'(2) : div_raw;
    half    = div >> 1;
  end

  assign lead_o  = busy_i && (pc_q == half - DIV_W'(1));
  assign trail_o = busy_i && (pc_q == div - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q  <= '0;
      sck_q <= 1'b0;
    end else if (!busy_i) begin
      pc_q  <= '0;
      sck_q <= cpol_i;
    end else begin
      pc_q <= trail_o ? '0 : pc_q + DIV_W'(1);
      if (lead_o)       sck_q <= ~cpol_i;
      else if (trail_o) sck_q <= cpol_i;
    end
  end

  assign sck_o = sck_q;

  assert_sck_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |=> (sck_o == $past(cpol_i)));
endmodule

// File: rtl/spi_bm_shift.sv
`timescale 1ns/1ps
module spi_bm_shift
  import spi_bm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              ph_first_i,
  input  logic              lead_i,
  input  logic              trail_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              mosi_o,
  output logic [BYTE_W-1:0] rx_byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic              busy_q, mosi_q;
  logic [CNT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] tx_q, rx_q;

  assign done_o = trail_i && (bit_q == CNT_W'(BYTE_W-1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      mosi_q <= 1'b0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      bit_q  <= '0;
      rx_q   <= '0;
      if (ph_first_i) begin
        mosi_q <= tx_byte_i[BYTE_W-1];
        tx_q   <= {tx_byte_i[BYTE_W-2:0], 1'b0};
      end else begin
        tx_q   <= tx_byte_i;
      end
    end else if (busy_q) begin
      if (lead_i) begin
        if (ph_first_i) rx_q <= {rx_q[BYTE_W-2:0], miso_i};
        else begin
          mosi_q <= tx_q[BYTE_W-1];
          tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
      if (trail_i) begin
        if (ph_first_i) begin
          mosi_q <= tx_q[BYTE_W-1];
          tx_q   <= {tx_q[BYTE_W-2:0], 1'b0};
        end else begin
          rx_q <= {rx_q[BYTE_W-2:0], miso_i};
        end
        bit_q <= bit_q + CNT_W'(1);
        if (done_o) busy_q <= 1'b0;
      end
    end
  end

  // trailing-edge mode takes its last sample on the completing edge
  assign rx_byte_o = ph_first_i ? rx_q : {rx_q[BYTE_W-2:0], miso_i};
  assign busy_o    = busy_q;
  assign mosi_o    = mosi_q;

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done_o |=> busy_q);
  assert_start_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/spi_byte_master.sv
`timescale 1ns/1ps
module spi_byte_master
  import spi_bm_pkg::*;
#(
  parameter int BUS_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       reg_addr_i,
  input  logic [BUS_W-1:0] reg_wdata_i,
  input  logic             reg_we_i,
  output logic [BUS_W-1:0] reg_rdata_o,
  output logic             sck_o,
  output logic             mosi_o,
  input  logic             miso_i,
  output logic [N_CS-1:0]  cs_n_o
);
  logic [SPR_W-1:0]  spr;
  logic [SPPR_W-1:0] sppr;
  logic              cpol, ph_first, cs_act, start, busy, done, lead, trail;
  logic [CS_W-1:0]   cs_num;
  logic [BYTE_W-1:0] tx_byte, rx_byte;

  spi_bm_regs #(.BUS_W(BUS_W)) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .we_i(reg_we_i), .rdata_o(reg_rdata_o),
    .busy_i(busy), .done_i(done), .rx_byte_i(rx_byte),
    .spr_o(spr), .sppr_o(sppr), .cpol_o(cpol), .ph_first_o(ph_first),
    .cs_num_o(cs_num), .cs_act_o(cs_act), .start_o(start), .tx_byte_o(tx_byte)
  );

  spi_bm_timer u_timer (
    .clk_i, .rst_ni, .busy_i(busy),
    .spr_i(spr), .sppr_i(sppr), .cpol_i(cpol),
    .lead_o(lead), .trail_o(trail), .sck_o(sck_o)
  );

  spi_bm_shift u_shift (
    .clk_i, .rst_ni, .start_i(start), .tx_byte_i(tx_byte), .ph_first_i(ph_first),
    .lead_i(lead), .trail_i(trail), .miso_i(miso_i),
    .busy_o(busy), .done_o(done), .mosi_o(mosi_o), .rx_byte_o(rx_byte)
  );

  for (genvar k = 0; k < N_CS; k++) begin : g_cs
    assign cs_n_o[k] = !(cs_act && (cs_num == CS_W'(k)));
  end

  assert_cs_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  assert_cs_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i && (reg_addr_i == ADDR_CTRL) && !reg_wdata_i[CTL_ACT] |=> &cs_n_o);
endmodule

// File: tb/sim_spi_byte_master.sv
`timescale 1ns/1ps
module sim_spi_byte_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0;
  logic [31:0] rdata;
  logic        sck, mosi, miso;
  logic [7:0]  cs_n;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  spi_byte_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_we_i(we), .reg_rdata_o(rdata), .sck_o(sck), .mosi_o(mosi),
    .miso_i(miso), .cs_n_o(cs_n)
  );

  // slave model: reacts at the falling core edge after each SCK change
  logic       cur_cpol = 1'b0, cur_ph = 1'b0, sck_prev = 1'b0;
  logic [7:0] s_tx = '0, s_rx = '0;
  int         s_idx = 0, s_edges = 0;
  initial miso = 1'b0;

  always @(negedge clk) begin
    if (sck !== sck_prev) begin
      s_edges++;
      if (sck != cur_cpol) begin
        if (cur_ph) s_rx = {s_rx[6:0], mosi};
        else if (s_idx < 8) miso = s_tx[7-s_idx];
      end else begin
        if (cur_ph) begin
          s_idx++;
          if (s_idx < 8) miso = s_tx[7-s_idx];
        end else begin
          s_rx = {s_rx[6:0], mosi};
          s_idx++;
        end
      end
    end
    sck_prev = sck;
  end

  // spr, sppr, cpol, phase, tx byte, slave byte
  localparam logic [24:0] VEC [8] = '{
    {4'd1, 3'd1, 1'b0, 1'b1, 8'hA5, 8'h3C},
    {4'd3, 3'd0, 1'b0, 1'b0, 8'h81, 8'h7E},
    {4'd2, 3'd2, 1'b1, 1'b1, 8'h5A, 8'hC3},
    {4'd5, 3'd1, 1'b1, 1'b0, 8'hFF, 8'h00},
    {4'd1, 3'd0, 1'b0, 1'b1, 8'h00, 8'hFF},
    {4'd0, 3'd2, 1'b1, 1'b0, 8'h96, 8'h69},
    {4'd7, 3'd0, 1'b0, 1'b1, 8'h12, 8'h34},
    {4'd3, 3'd3, 1'b1, 1'b1, 8'hE7, 8'h18}
  };

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  function automatic int div_of(input int spr, input int sppr);
    int e = (spr == 0) ? 1 : spr;
    int d = e << sppr;
    return (d < 2) ? 2 : d;
  endfunction

  function automatic logic [31:0] cfg_word(input logic [3:0] spr, input logic [2:0] sppr,
                                           input logic cpol, input logic ph);
    return {23'd0, ph, cpol, sppr[2:1], sppr[0], spr};
  endfunction

  task automatic setup(input logic [3:0] spr, input logic [2:0] sppr, input logic cpol,
                       input logic ph, input logic [7:0] stx, input int csn);
    logic [31:0] r;
    wr(2'd0, cfg_word(spr, sppr, cpol, ph));
    @(negedge clk); @(negedge clk);
    rd(2'd0, r);
    chk(r == cfg_word(spr, sppr, cpol, ph), "R2", "config readback", r, cfg_word(spr, sppr, cpol, ph));
    wr(2'd1, {27'd0, 3'(csn), 1'b1, 1'b0});
    chk(cs_n == ~(8'd1 << csn), "R6", "chip select decode", cs_n, ~(8'd1 << csn));
    chk(sck == cpol, "R4", "idle sck level", sck, cpol);
    cur_cpol = cpol; cur_ph = ph; s_tx = stx; s_rx = '0;
    s_idx = 0; s_edges = 0;
    miso = ph ? stx[7] : 1'b0;
  endtask

  task automatic run_byte(input logic [7:0] tx, input bit inject, output int n);
    wr(2'd2, {24'd0, tx});
    addr = 2'd1;
    #1;
    n = 0;
    while (rdata[0] !== 1'b1 && n < 20000) begin
      @(negedge clk);
      n++;
      if (inject && n == 5) begin addr = 2'd2; wdata = '0; we = 1'b1; end
      else if (inject && n == 6) begin we = 1'b0; addr = 2'd1; end
      #1;
    end
  endtask

  task automatic byte_checks(input logic [7:0] tx, input logic [7:0] stx,
                             input logic cpol, input int d, input int n, input string tag);
    logic [31:0] r;
    chk(n == 8*d, "R1", {tag, " cycles per byte"}, n, 8*d);
    chk(s_edges == 16, "R4", {tag, " sck transitions"}, s_edges, 16);
    chk(sck == cpol, "R4", {tag, " sck back at idle"}, sck, cpol);
    chk(s_rx == tx, "R3", {tag, " byte seen by slave"}, s_rx, tx);
    rd(2'd3, r);
    chk(r == {24'd0, stx}, "R5", {tag, " received byte"}, r, stx);
    rd(2'd1, r);
    chk(r[0] == 1'b1, "R7", {tag, " flag set on completion"}, r[0], 1);
    wr(2'd1, {27'd0, r[4:2], 1'b1, 1'b0});
  endtask

  initial begin
    #(200000 * 4);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(cs_n == 8'hFF, "R9", "reset chip selects", cs_n, 8'hFF);
    chk(sck == 1'b0, "R9", "reset sck", sck, 0);
    chk(mosi == 1'b0, "R9", "reset mosi", mosi, 0);
    rd(2'd0, r); chk(r == 0, "R9", "reset config", r, 0);
    rd(2'd1, r); chk(r == 0, "R9", "reset control", r, 0);
    rd(2'd3, r); chk(r == 0, "R9", "reset rx data", r, 0);

    // vector walk; vector 5 has SPR=0 (R10), vector 4 clamps D to 2 (R1)
    for (int i = 0; i < 8; i++) begin
      logic [24:0] v = VEC[i];
      int d = div_of(int'(v[24:21]), int'(v[20:18]));
      setup(v[24:21], v[20:18], v[17], v[16], v[7:0], i);
      run_byte(v[15:8], 1'b0, n);
      byte_checks(v[15:8], v[7:0], v[17], d, n, (i == 5) ? "R10 vector" : "vector");
    end

    // R8: transmit write while busy is ignored
    setup(4'd2, 3'd1, 1'b0, 1'b0, 8'h5B, 2);
    run_byte(8'hC6, 1'b1, n);
    byte_checks(8'hC6, 8'h5B, 1'b0, 4, n, "R8 overlapping write");

    // R7: flag handling
    setup(4'd1, 3'd1, 1'b1, 1'b1, 8'h0F, 6);
    run_byte(8'hF0, 1'b0, n);
    wr(2'd1, {27'd0, 3'd6, 1'b1, 1'b1});
    rd(2'd1, r); chk(r[0] == 1'b1, "R7", "write 1 keeps flag set", r[0], 1);
    wr(2'd1, {27'd0, 3'd6, 1'b1, 1'b0});
    rd(2'd1, r); chk(r[0] == 1'b0, "R7", "write 0 clears flag", r[0], 0);
    wr(2'd1, {27'd0, 3'd6, 1'b1, 1'b1});
    rd(2'd1, r); chk(r[0] == 1'b0, "R7", "write 1 does not set flag", r[0], 0);
    rd(2'd2, r); chk(r == 0, "R5", "transmit address reads 0", r, 0);

    // R6: release
    wr(2'd1, {27'd0, 3'd6, 1'b0, 1'b0});
    chk(cs_n == 8'hFF, "R6", "chip selects released", cs_n, 8'hFF);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule